// File: doc/BRIEF.md
# Auto-Ranging 16x Baud Tick Generator

This block makes the 16x oversampling tick that the asynchronous/synchronous converter channels use. It runs on the crystal clock. In internal timing mode it divides the crystal clock by one of ten ratios. Three of the ratios are fractional: 64/3, 128/5 and 128/3. A phase accumulator spreads the ticks of a fractional ratio evenly, so every tick is one crystal cycle wide.

The block picks the ratio itself. It synchronises the synchronous transmit clock into the crystal domain and counts crystal cycles between its rising edges. It then maps that count to the nearest ideal count, which is 16 times the divide ratio. A new ratio takes effect only when two back-to-back measurements agree. The crystal is meant to run at 128 times the fastest bit rate. Index 0 is therefore the fastest rate (divide by 8), and index 9 is the slowest (divide by 512).

In external timing mode the tick is taken from a 16x clock supplied on an input pin. The divider output is not used in that mode, but rate measurement keeps running.

Top module: `baud16_autorange`

## Requirements
- R1: While reset is held low, and after it is released, `rate_idx` reads 0 (divide by 8) and `tick16` is low until the first tick is due.
- R2: The rate index is chosen from the crystal cycle count C measured over one transmit clock period. Index k has the ratio num/den from this list, in index order: 8/1, 16/1, 64/3, 128/5, 32/1, 128/3, 64/1, 128/1, 256/1, 512/1. The ideal count for index k is 16·num/den. The chosen index is the one whose ideal count is nearest to C, so C=298 gives 1 and C=299 gives 2. `rate_idx` is always below 10.
- R3: `rate_idx` changes only when two consecutive measurements give the same index. A single transmit period of a different length leaves `rate_idx` unchanged.
- R4: In internal mode with an integer ratio N, `tick16` is a one-cycle pulse every N crystal cycles. Two ticks are never adjacent.
- R5: In internal mode with a fractional ratio num/den, exactly den ticks occur in every num crystal cycles. The nth cycle after the phase restart carries a tick exactly when floor(n·den/num) > floor((n−1)·den/num).
- R6: When `rate_idx` changes, the divider phase restarts. No tick occurs in that cycle, and the cycle count n of R5 restarts from 0 there (after reset it also starts from 0).
- R7: With `int_timing`=0, `tick16` pulses for one cycle two crystal cycles after each rising edge of `ext16_in` is sampled, and at no other time.
- R8: With `int_timing`=0 the divider produces no ticks on `tick16`, but rate measurement keeps updating `rate_idx`.
- R9: After reset, the first transmit clock edge only starts a measurement. The first period measured is the one that ends at the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal clock; all state runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| txc_in | input | 1 | Synchronous transmit clock, asynchronous to the crystal clock |
| int_timing | input | 1 | 1 = internal divider with automatic rate selection, 0 = external 16x clock |
| ext16_in | input | 1 | External 16x clock, used when `int_timing` is 0 |
| tick16 | output | 1 | One-cycle 16x oversampling tick |
| rate_idx | output | 4 | Committed rate index, 0 (divide by 8) to 9 (divide by 512) |

## Verification
A wrong committed index shows on `rate_idx` within about three transmit periods of a rate change. A bad threshold shows at once as the wrong index at the boundary counts 298 and 299. A fault in the accumulator shows as a `tick16` spacing that differs from the floor pattern, within one tick interval (at most 512 cycles). A missing phase restart moves every later tick, so the cycle-by-cycle model flags it one tick after the change. In external mode, a wrong synchroniser depth or a leak from the divider shows on the first `ext16_in` edge, or on the first divider tick that should not appear.

// File: rtl/baud16_pkg.sv
package baud16_pkg;
  localparam int N_RATES = 10;
  localparam int IDX_W   = 4;
  localparam int MAX_NUM = 512;

  // numerator of the crystal cycles per tick ratio
  function automatic int unsigned rate_num(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0: rate_num = 8;
      4'd1: rate_num = 16;
      4'd2: rate_num = 64;
      4'd3: rate_num = 128;
      4'd4: rate_num = 32;
      4'd5: rate_num = 128;
      4'd6: rate_num = 64;
      4'd7: rate_num = 128;
      4'd8: rate_num = 256;
      4'd9: rate_num = 512;
      default: rate_num = 8;
    endcase
  endfunction

  // denominator of the ratio
  function automatic int unsigned rate_den(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd2, 4'd5: rate_den = 3;
      4'd3:       rate_den = 5;
      default:    rate_den = 1;
    endcase
  endfunction

  // nearest ideal count 16*num/den, compared against midpoints in integers
  function automatic logic [IDX_W-1:0] classify(input int unsigned count);
    int unsigned lhs, rhs;
    classify = '0;
    for (int k = 0; k < N_RATES - 1; k++) begin
      lhs = 2 * count * rate_den(IDX_W'(k)) * rate_den(IDX_W'(k + 1));
      rhs = 16 * (rate_num(IDX_W'(k)) * rate_den(IDX_W'(k + 1)) +
                  rate_num(IDX_W'(k + 1)) * rate_den(IDX_W'(k)));
      if (lhs >= rhs) classify = IDX_W'(k + 1);
    end
  endfunction
endpackage

// File: rtl/baud16_edge_sync.sv
module baud16_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], d_in};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/baud16_period_meter.sv
module baud16_period_meter
  import baud16_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             edge_i,
  output logic             meas_done,
  output logic [IDX_W-1:0] meas_idx,
  output logic [IDX_W-1:0] cand_idx,
  output logic             commit,
  output logic [IDX_W-1:0] rate_q
);
  logic             armed_q;
  logic             cand_v_q;
  logic [CNT_W-1:0] cnt_q;

  assign meas_done = edge_i & armed_q;
  assign meas_idx  = classify(32'(cnt_q));
  assign commit    = meas_done & cand_v_q & (meas_idx == cand_idx) &
                     (meas_idx != rate_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      cand_v_q <= 1'b0;
      cnt_q    <= '0;
      cand_idx <= '0;
      rate_q   <= '0;
    end else if (edge_i) begin
      armed_q <= 1'b1;
      cnt_q   <= CNT_W'(1);
      if (meas_done) begin
        cand_idx <= meas_idx;
        cand_v_q <= 1'b1;
      end
      if (commit) rate_q <= meas_idx;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/baud16_frac_div.sv
module baud16_frac_div
  import baud16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [IDX_W-1:0] rate_i,
  output logic             tick_q
);
  localparam int ACC_W = $clog2(MAX_NUM) + 1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             wrap;
  int unsigned      num, den, nxt;

  always_comb begin
    num   = rate_num(rate_i);
    den   = rate_den(rate_i);
    nxt   = 32'(acc_q) + den;
    wrap  = (nxt >= num);
    acc_d = wrap ? ACC_W'(nxt - num) : ACC_W'(nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (restart) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= wrap;
    end
  end
endmodule

// File: rtl/baud16_autorange.sv
module baud16_autorange
  import baud16_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_xtal,
  input  logic             rst_n,
  input  logic             txc_in,
  input  logic             int_timing,
  input  logic             ext16_in,
  output logic             tick16,
  output logic [IDX_W-1:0] rate_idx
);
  logic             txc_rise, ext_rise;
  logic             meas_done, commit, div_tick;
  logic [IDX_W-1:0] meas_idx, cand_idx;

  baud16_edge_sync #(.STAGES(SYNC_STAGES)) u_txc_sync (
    .clk(clk_xtal), .rst_n(rst_n), .d_in(txc_in), .rise(txc_rise));

  baud16_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk_xtal), .rst_n(rst_n), .d_in(ext16_in), .rise(ext_rise));

  baud16_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk_xtal), .rst_n(rst_n), .edge_i(txc_rise),
    .meas_done(meas_done), .meas_idx(meas_idx), .cand_idx(cand_idx),
    .commit(commit), .rate_q(rate_idx));

  baud16_frac_div u_div (
    .clk(clk_xtal), .rst_n(rst_n), .restart(commit),
    .rate_i(rate_idx), .tick_q(div_tick));

  assign tick16 = int_timing ? div_tick : ext_rise;
endmodule

// File: rtl/baud16_autorange_chk.sv
module baud16_autorange_chk
  import baud16_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             int_timing,
  input logic             tick16,
  input logic [IDX_W-1:0] rate_idx,
  input logic             meas_done,
  input logic [IDX_W-1:0] meas_idx,
  input logic [IDX_W-1:0] cand_idx,
  input logic             div_tick
);
  AST_RATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rate_idx < IDX_W'(N_RATES)); // R2

  AST_COMMIT_AGREED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_idx) |-> ($past(meas_done) && $past(meas_idx) == rate_idx &&
                            $past(cand_idx) == rate_idx)); // R3

  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_idx) |-> !div_tick); // R6

  AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> !div_tick); // R4

  AST_EXT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_timing && tick16) |=> (int_timing || !tick16)); // R7
endmodule

bind baud16_autorange baud16_autorange_chk chk_i (
  .clk(clk_xtal), .rst_n(rst_n), .int_timing(int_timing), .tick16(tick16),
  .rate_idx(rate_idx), .meas_done(meas_done), .meas_idx(meas_idx),
  .cand_idx(cand_idx), .div_tick(div_tick));

// File: tb/baud16_autorange_tb_top.sv
`timescale 1ns/1ps
module baud16_autorange_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txc_in = 1'b0;
  logic       int_timing = 1'b1;
  logic       ext16_in = 1'b0;
  logic       tick16;
  logic [3:0] rate_idx;

  int checks = 0;
  int fails  = 0;
  int txc_period = 0;
  int glitch_p = 0;
  bit done = 1'b0;

  // ratio table, index order from the requirements
  int NUM[10] = '{8, 16, 64, 128, 32, 128, 64, 128, 256, 512};
  int DEN[10] = '{1, 1, 3, 5, 1, 3, 1, 1, 1, 1};

  baud16_autorange dut_i (
    .clk_xtal(clk), .rst_n(rst_n), .txc_in(txc_in), .int_timing(int_timing),
    .ext16_in(ext16_in), .tick16(tick16), .rate_idx(rate_idx));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nearest(input int c);
    real best, d;
    nearest = 0;
    best = 1.0e9;
    for (int k = 0; k < 10; k++) begin
      d = 16.0 * NUM[k] / DEN[k] - c;
      if (d < 0.0) d = -d;
      if (d < best) begin best = d; nearest = k; end
    end
  endfunction

  // transmit clock generator, period in crystal cycles
  initial begin
    forever begin
      @(posedge clk);
      if (txc_period == 0) begin
        #2 txc_in = 1'b0;
      end else begin
        int p;
        p = (glitch_p != 0) ? glitch_p : txc_period;
        glitch_p = 0;
        #2 txc_in = 1'b1;
        repeat (p / 2) @(posedge clk);
        #2 txc_in = 1'b0;
        repeat (p - p / 2 - 1) @(posedge clk);
      end
    end
  end

  // cycle reference model: inputs seen at the edge, outputs compared off the edge
  bit rst_pe, ext_pe;
  int n = 0;
  int prev_r = 0;
  bit h0, h1, h2;
  always @(posedge clk) begin
    rst_pe = rst_n;
    ext_pe = ext16_in;
  end
  always @(negedge clk) begin
    bit exp_div, exp_t;
    int r;
    r = rate_idx;
    exp_div = 1'b0;
    if (!rst_n || !rst_pe) begin
      n = 0; prev_r = 0; h0 = 0; h1 = 0; h2 = 0;
      if (!rst_n) check(rate_idx == 0, "R1 rate in reset", r, 0);
    end else begin
      h2 = h1; h1 = h0; h0 = ext_pe;
      if (r != prev_r || r > 9) begin
        n = 0;
      end else begin
        n++;
        exp_div = ((n * DEN[r]) / NUM[r]) != (((n - 1) * DEN[r]) / NUM[r]);
      end
      prev_r = r;
    end
    exp_t = int_timing ? exp_div : (h1 & ~h2);
    check(tick16 == exp_t, "R5/R6/R7 tick model", tick16, exp_t);
  end

  task automatic cyc(input int k);
    repeat (k) @(posedge clk);
    #2;
  endtask

  task automatic count_ticks(input int w, output int c);
    c = 0;
    repeat (w) begin
      @(negedge clk);
      if (tick16) c++;
    end
  endtask

  task automatic settle(input int p_old, input int p_new, input string tag);
    txc_period = p_new;
    cyc(p_old + 4 * p_new);
    check(rate_idx == nearest(p_new), tag, rate_idx, nearest(p_new));
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int c;
    cyc(5);
    check(rate_idx == 0, "R1 rate index in reset", rate_idx, 0);
    check(tick16 == 0, "R1 tick low in reset", tick16, 0);
    rst_n = 1'b1;
    cyc(3);
    check(rate_idx == 0, "R1 rate index after reset", rate_idx, 0);
    count_ticks(80, c);
    check(c == 10, "R4 divide by 8 default", c, 10);

    settle(0, 256, "R2 period 256");
    count_ticks(160, c);
    check(c == 10, "R4 divide by 16", c, 10);
    settle(256, 341, "R2 period 341");
    count_ticks(640, c);
    check(c == 30, "R5 divide by 64/3", c, 30);
    settle(341, 410, "R2 period 410");
    count_ticks(1280, c);
    check(c == 50, "R5 divide by 128/5", c, 50);
    settle(410, 683, "R2 period 683");
    count_ticks(1280, c);
    check(c == 30, "R5 divide by 128/3", c, 30);
    settle(683, 298, "R2 boundary 298");
    check(rate_idx == 1, "R2 298 maps to 1", rate_idx, 1);
    settle(298, 299, "R2 boundary 299");
    check(rate_idx == 2, "R2 299 maps to 2", rate_idx, 2);
    settle(299, 256, "R2 back to 256");

    glitch_p = 512;
    cyc(512 + 6 * 256);
    check(rate_idx == 1, "R3 single long period ignored", rate_idx, 1);

    settle(256, 1024, "R2 period 1024");
    settle(1024, 2048, "R2 period 2048");
    count_ticks(1280, c);
    check(c == 10, "R4 divide by 128", c, 10);

    int_timing = 1'b0;
    cyc(4);
    fork
      count_ticks(610, c);
      begin
        repeat (100) begin
          ext16_in = 1'b1; cyc(3);
          ext16_in = 1'b0; cyc(3);
        end
      end
    join
    check(c == 100, "R7 external tick per edge", c, 100);
    count_ticks(300, c);
    check(c == 0, "R8 divider silent in external mode", c, 0);
    settle(2048, 128, "R8 measurement in external mode");
    int_timing = 1'b1;

    txc_period = 0;
    cyc(600);
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    txc_period = 256;
    cyc(400);
    check(rate_idx == 0, "R9 first edge only arms", rate_idx, 0);
    cyc(300);
    check(rate_idx == 1, "R9 commit after second agreeing period", rate_idx, 1);

    done = 1'b1;
    summary();
  end
endmodule